// File: doc/BRIEF.md
# Two-Channel Cycle-Steal DMA Controller

This block moves data on behalf of the CPU by taking one bus transfer at a time. It has two channels. Each channel holds a source address, a destination address, a 16-bit transfer counter with its reload value, and control bits for enable, repeat mode, unit size (8 or 16 bits) and which side, if any, steps forward. Each rising edge on a channel's request input queues one transfer. A transfer is a read beat at the source followed by a write beat at the destination, and the write carries the data that was read. Each transfer ends by stepping the forward pointer and decrementing the counter.

Software reaches the registers through a simple access port. The enable bit controls which fields software may write and what it reads back. When the counter of a channel underflows, the channel raises a one-cycle interrupt pulse. In single mode the channel then shuts itself off. In repeat mode it reloads the counter and keeps running. The address range 0x20 to 0x3F is reserved for the controller's own registers, so a transfer that touches it is carried out without any bus beat.

The bus-master side is a valid/ready stream. `bus_req` is valid and `bus_gnt` is ready. While `bus_gnt` is low, the controller holds the beat: `bus_req` stays high and `bus_we`, `bus_addr` and `bus_wdata` do not change until the beat is accepted. A beat completes on a clock edge where both signals are high. For a read beat, `bus_rdata` is taken on that edge.

Top module: `dma2ch`

## Requirements
- R1: After reset, every register reads 0, `bus_req` is low and `irq` is 0.
- R2: When both channels have a transfer pending in the same cycle, channel 0 is started first and channel 1 is started after channel 0 finishes.
- R3: Each rising edge of `dreq[i]` while channel i is enabled causes exactly one transfer: a read beat at the source, then a write beat at the destination carrying the read data. An edge that arrives while the channel is disabled is dropped. Requests that arrive while a transfer is already queued merge into that single pending transfer.
- R4: While `bus_req` is high and `bus_gnt` is low, `bus_req` stays high and the beat's `bus_we`, `bus_addr` and `bus_wdata` are unchanged.
- R5: The forward side steps by 1 for 8-bit units and by 2 for 16-bit units, and wraps modulo 2^20. The fixed side does not move. If both forward bits are set, only the source steps. An 8-bit unit writes the read low byte with the upper byte zero.
- R6: The first transfer after the enable bit goes from 0 to 1 loads the forward pointer from the forward-side register and the counter from the reload register.
- R7: A counter loaded with N gives N+1 transfers. The underflow on the last of them produces a one-cycle pulse on `irq[i]`.
- R8: In single mode, an underflow clears the enable bit.
- R9: In repeat mode, an underflow reloads the counter and leaves the channel enabled. The forward pointer keeps advancing and is not reloaded.
- R10: A write to the forward-side address register is always accepted. A write to a fixed-side address register is ignored while the channel is enabled. Writes to the reload and control registers are always accepted.
- R11: Every register is readable at all times. While the channel is enabled and its pointer is loaded, reading the forward-side address returns the live pointer.
- R12: If either address of a transfer lies in 0x20 to 0x3F, no bus beat is issued, but the counter and pointer still advance as if the transfer had taken place.

Register map: `reg_addr[2]` selects the channel and `reg_addr[1:0]` selects the register:
- 0: source address
- 1: destination address
- 2: reload value (16 bits)
- 3: control

Control register bits:
- bit 0: enable
- bit 1: repeat mode
- bit 2: 16-bit unit
- bit 3: source steps forward
- bit 4: destination steps forward

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Channel and register select |
| reg_wdata | input | 20 | Register write data |
| reg_rdata | output | 20 | Register read data (combinational) |
| dreq | input | 2 | Per-channel transfer request, rising-edge sensitive |
| bus_req | output | 1 | Bus beat valid |
| bus_gnt | input | 1 | Bus beat ready |
| bus_we | output | 1 | Beat is a write |
| bus_wide | output | 1 | Beat is 16 bits wide |
| bus_addr | output | 20 | Beat address |
| bus_wdata | output | 16 | Write beat data |
| bus_rdata | input | 16 | Read beat data, taken on acceptance |
| irq | output | 2 | Per-channel underflow pulse |

## Verification
The assertions assume several things about the block's inputs:
- `dreq` is a level sampled once per clock.
- The bus side accepts a beat only by raising `bus_gnt` and never withdraws read data after acceptance.
- Software does not rewrite the control register in the same cycle that a channel underflows.

The stimulus keeps within these assumptions. All inputs change only on the falling edge, and requests are pulsed while the controller is idle. The bus model answers reads combinationally from the address and stalls only by holding `bus_gnt` low for a whole stretch. Control writes are issued only between bursts, after the expected transfers have drained.

// File: rtl/dma2ch_pkg.sv
package dma2ch_pkg;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 16;
  localparam int NCH    = 2;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RD   = 2'd1,
    ENG_WR   = 2'd2
  } eng_state_e;

  typedef struct packed {
    logic dst_fwd;
    logic src_fwd;
    logic wide;
    logic rpt;
    logic en;
  } chan_ctl_t;

  localparam int CTL_W = $bits(chan_ctl_t);
endpackage

// File: rtl/dma2ch_chan.sv
module dma2ch_chan
  import dma2ch_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    reg_idx,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] rd_data,
  input  logic          req_in,
  input  logic          start,
  input  logic          done,
  output logic          pend,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          wide,
  output logic          irq
);
  chan_ctl_t     ctl;
  logic [AW-1:0] src_q, dst_q, fptr_q;
  logic [CW-1:0] rld_q, cnt_q;
  logic          first_q, req_d, pend_q, irq_q;
  logic          src_is_fwd, dst_is_fwd, loaded;
  logic [AW-1:0] step;

  assign src_is_fwd = ctl.src_fwd;
  assign dst_is_fwd = ctl.dst_fwd & ~ctl.src_fwd;
  assign loaded     = ctl.en & ~first_q;
  assign step       = ctl.wide ? AW'(2) : AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl     <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      fptr_q  <= '0;
      rld_q   <= '0;
      cnt_q   <= '0;
      first_q <= 1'b0;
      req_d   <= 1'b0;
      pend_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      req_d <= req_in;
      irq_q <= done && (cnt_q == '0);
      if (wr_en) begin
        case (reg_idx)
          2'd0: if (src_is_fwd || !ctl.en) src_q <= wr_data;
          2'd1: if (dst_is_fwd || !ctl.en) dst_q <= wr_data;
          2'd2: rld_q <= wr_data[CW-1:0];
          default: begin
            ctl <= chan_ctl_t'(wr_data[CTL_W-1:0]);
            if (wr_data[0] && !ctl.en) first_q <= 1'b1;
          end
        endcase
      end
      if (start && first_q) begin
        cnt_q   <= rld_q;
        fptr_q  <= src_is_fwd ? src_q : dst_q;
        first_q <= 1'b0;
      end
      if (done) begin
        fptr_q <= fptr_q + step;
        if (cnt_q == '0) begin
          if (ctl.rpt) cnt_q <= rld_q;
          else         ctl.en <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
      if (start)   pend_q <= 1'b0;
      if (!ctl.en) pend_q <= 1'b0;
      else if (req_in && !req_d) pend_q <= 1'b1;
    end
  end

  assign pend     = pend_q & ctl.en;
  assign wide     = ctl.wide;
  assign irq      = irq_q;
  assign src_addr = (src_is_fwd && loaded) ? fptr_q : src_q;
  assign dst_addr = (dst_is_fwd && loaded) ? fptr_q : dst_q;

  always_comb begin
    case (reg_idx)
      2'd0:    rd_data = src_addr;
      2'd1:    rd_data = dst_addr;
      2'd2:    rd_data = {{(AW-CW){1'b0}}, rld_q};
      default: rd_data = {{(AW-CTL_W){1'b0}}, ctl};
    endcase
  end

  // R8: single mode goes inactive on underflow
  p_single_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cnt_q == '0 && !ctl.rpt) |=> !ctl.en);
  // R9: repeat mode stays active on underflow unless software rewrites control
  p_repeat_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cnt_q == '0 && ctl.rpt && ctl.en && !(wr_en && reg_idx == 2'd3)) |=> ctl.en);
  // R7: the interrupt is a single-cycle pulse
  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R6: a first start consumes the load flag
  p_first_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && first_q && !(wr_en && reg_idx == 2'd3)) |=> !first_q && cnt_q == $past(rld_q));
endmodule

// File: rtl/dma2ch_eng.sv
module dma2ch_eng
  import dma2ch_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int N  = NCH
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          pend,
  input  logic [N-1:0][AW-1:0]  src_a,
  input  logic [N-1:0][AW-1:0]  dst_a,
  input  logic [N-1:0]          wide,
  output logic [N-1:0]          start,
  output logic [N-1:0]          done,
  output logic                  bus_req,
  input  logic                  bus_gnt,
  output logic                  bus_we,
  output logic                  bus_wide,
  output logic [AW-1:0]         bus_addr,
  output logic [DW-1:0]         bus_wdata,
  input  logic [DW-1:0]         bus_rdata
);
  localparam int SW = (N > 1) ? $clog2(N) : 1;

  eng_state_e    state;
  logic [SW-1:0] sel_q, pick;
  logic          found;
  logic [DW-1:0] data_q;
  logic [AW-1:0] cur_src, cur_dst;
  logic          skip;

  function automatic logic in_regs(input logic [AW-1:0] a);
    return (a[AW-1:6] == '0) && a[5];
  endfunction

  assign cur_src = src_a[sel_q];
  assign cur_dst = dst_a[sel_q];
  assign skip    = in_regs(cur_src) | in_regs(cur_dst);

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && !found) begin
        pick  = SW'(i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    start     = '0;
    done      = '0;
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    bus_wide  = wide[sel_q];
    case (state)
      ENG_IDLE: if (found) start[pick] = 1'b1;
      ENG_RD: begin
        if (skip) done[sel_q] = 1'b1;
        else begin
          bus_req  = 1'b1;
          bus_addr = cur_src;
        end
      end
      ENG_WR: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = cur_dst;
        bus_wdata = data_q;
        if (bus_gnt) done[sel_q] = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ENG_IDLE;
      sel_q  <= '0;
      data_q <= '0;
    end else begin
      case (state)
        ENG_IDLE: if (found) begin
          sel_q <= pick;
          state <= ENG_RD;
        end
        ENG_RD: begin
          if (skip) state <= ENG_IDLE;
          else if (bus_gnt) begin
            data_q <= wide[sel_q] ? bus_rdata : {{(DW-8){1'b0}}, bus_rdata[7:0]};
            state  <= ENG_WR;
          end
        end
        ENG_WR: if (bus_gnt) state <= ENG_IDLE;
        default: state <= ENG_IDLE;
      endcase
    end
  end

  // R12: no beat ever reaches the controller's own register range
  p_no_reg_hit_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !in_regs(bus_addr));
  // R4: a stalled beat stays offered with the same direction and data
  p_hold_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req && $stable(bus_we) && $stable(bus_wdata));
  // R2: the lowest-numbered pending channel wins
  p_ch0_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ENG_IDLE && pend[0]) |-> start[0]);
  // R3: at most one transfer completes per cycle
  p_one_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done));
endmodule

// File: rtl/dma2ch.sv
module dma2ch
  import dma2ch_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic [1:0]    dreq,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_we,
  output logic          bus_wide,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic [1:0]    irq
);
  localparam int N = 2;

  logic [N-1:0]         pend, start, done, wide;
  logic [N-1:0][AW-1:0] src_a, dst_a, rd;

  for (genvar g = 0; g < N; g++) begin : g_ch
    dma2ch_chan #(.AW(AW), .CW(CW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_we && (reg_addr[2] == 1'(g))),
      .reg_idx  (reg_addr[1:0]),
      .wr_data  (reg_wdata),
      .rd_data  (rd[g]),
      .req_in   (dreq[g]),
      .start    (start[g]),
      .done     (done[g]),
      .pend     (pend[g]),
      .src_addr (src_a[g]),
      .dst_addr (dst_a[g]),
      .wide     (wide[g]),
      .irq      (irq[g])
    );
  end

  assign reg_rdata = rd[reg_addr[2]];

  dma2ch_eng #(.AW(AW), .DW(DW), .N(N)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend),
    .src_a     (src_a),
    .dst_a     (dst_a),
    .wide      (wide),
    .start     (start),
    .done      (done),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .bus_we    (bus_we),
    .bus_wide  (bus_wide),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );
endmodule

// File: tb/dma2ch_tb_top.sv
module dma2ch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [19:0] reg_wdata = '0;
  logic [19:0] reg_rdata;
  logic [1:0]  dreq = '0;
  logic        bus_req, bus_we, bus_wide;
  logic        bus_gnt = 1'b1;
  logic [19:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [1:0]  irq;

  int n_chk = 0;
  int n_fail = 0;
  int wr_n = 0;
  int irq_n0 = 0;
  int irq_n1 = 0;
  int reg_hits = 0;
  logic [19:0] log_addr [64];
  logic [15:0] log_data [64];

  always #5 clk = ~clk;

  assign bus_rdata = bus_addr[15:0] ^ 16'h5A3C;

  dma2ch dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_we(bus_we), .bus_wide(bus_wide),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always @(posedge clk) begin
    if (bus_req && bus_addr >= 20'h20 && bus_addr <= 20'h3F) reg_hits <= reg_hits + 1;
    if (bus_req && bus_gnt && bus_we && wr_n < 64) begin
      log_addr[wr_n] <= bus_addr;
      log_data[wr_n] <= bus_wdata;
      wr_n <= wr_n + 1;
    end
    if (irq[0]) irq_n0 <= irq_n0 + 1;
    if (irq[1]) irq_n1 <= irq_n1 + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int idx, input logic [19:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = {1'(ch), 2'(idx)}; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int ch, input int idx, output logic [19:0] d);
    @(negedge clk);
    reg_addr = {1'(ch), 2'(idx)};
    #1 d = reg_rdata;
  endtask

  task automatic req_pulse(input logic [1:0] m);
    @(negedge clk); dreq = m;
    @(negedge clk); dreq = 2'b00;
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [15:0] exp16(input logic [19:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  task automatic t_reset;
    logic [19:0] v;
    for (int c = 0; c < 2; c++) for (int i = 0; i < 4; i++) begin
      rd(c, i, v); chk("R1 reg reset", v, 0);
    end
    chk("R1 bus_req idle", bus_req, 0);
    chk("R1 irq idle", irq, 0);
  endtask

  task automatic t_single16;
    int b = wr_n; int q = irq_n0; logic [19:0] v;
    wr(0, 0, 20'h00100); wr(0, 1, 20'h04000); wr(0, 2, 20'd2); wr(0, 3, 20'h0D);
    for (int k = 0; k < 3; k++) req_pulse(2'b01);
    chk("R7 N+1 transfers", wr_n - b, 3);
    for (int k = 0; k < 3; k++) begin
      chk("R5 fixed dest", log_addr[b+k], 20'h04000);
      chk("R3 data from stepped src", log_data[b+k], exp16(20'h00100 + 20'(2*k)));
    end
    chk("R7 one irq", irq_n0 - q, 1);
    rd(0, 3, v); chk("R8 enable cleared", v, 20'h0C);
    rd(0, 0, v); chk("R11 reg value when off", v, 20'h00100);
  endtask

  task automatic t_byte_dst;
    int b = wr_n; logic [19:0] v;
    wr(1, 0, 20'h08000); wr(1, 1, 20'h09000); wr(1, 2, 20'd3); wr(1, 3, 20'h11);
    req_pulse(2'b10);
    rd(1, 1, v); chk("R11 live pointer", v, 20'h09001);
    wr(1, 0, 20'h0ABCD);
    rd(1, 0, v); chk("R10 fixed write ignored", v, 20'h08000);
    wr(1, 1, 20'h0A000);
    for (int k = 0; k < 3; k++) req_pulse(2'b10);
    chk("R7 count", wr_n - b, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R5 byte step", log_addr[b+k], 20'h09000 + 20'(k));
      chk("R5 byte data", log_data[b+k], 16'h003C);
    end
    rd(1, 1, v); chk("R10 forward write kept", v, 20'h0A000);
  endtask

  task automatic t_repeat;
    int b = wr_n; int q = irq_n0; logic [19:0] v;
    wr(0, 0, 20'h00200); wr(0, 1, 20'h00300); wr(0, 2, 20'd1); wr(0, 3, 20'h0F);
    for (int k = 0; k < 4; k++) req_pulse(2'b01);
    chk("R9 two underflows", irq_n0 - q, 2);
    rd(0, 3, v); chk("R9 still enabled", v, 20'h0F);
    chk("R9 pointer continues", log_data[b+3], exp16(20'h00206));
    wr(0, 3, 20'h0E); wr(0, 3, 20'h0F);
    req_pulse(2'b01);
    chk("R6 reload after enable", log_data[b+4], exp16(20'h00200));
    wr(0, 3, 20'h0E);
  endtask

  task automatic t_prio;
    int b = wr_n;
    wr(0, 0, 20'h01000); wr(0, 1, 20'h01100); wr(0, 2, 20'd5); wr(0, 3, 20'h05);
    wr(1, 0, 20'h02000); wr(1, 1, 20'h02100); wr(1, 2, 20'd5); wr(1, 3, 20'h05);
    req_pulse(2'b11);
    chk("R2 ch0 first", log_addr[b], 20'h01100);
    chk("R2 ch1 second", log_addr[b+1], 20'h02100);
    wr(0, 3, 0); wr(1, 3, 0);
  endtask

  task automatic t_protected;
    int b = wr_n; int q = irq_n1; logic [19:0] v;
    wr(1, 0, 20'h00025); wr(1, 1, 20'h05000); wr(1, 2, 0); wr(1, 3, 20'h05);
    req_pulse(2'b10);
    chk("R12 no beat", wr_n - b, 0);
    chk("R12 counted", irq_n1 - q, 1);
    rd(1, 3, v); chk("R12 single done", v, 20'h04);
  endtask

  task automatic t_both_fwd;
    int b = wr_n;
    wr(0, 0, 20'h00600); wr(0, 1, 20'h00700); wr(0, 2, 20'd1); wr(0, 3, 20'h1D);
    req_pulse(2'b01); req_pulse(2'b01);
    chk("R5 dest fixed", log_addr[b+1], 20'h00700);
    chk("R5 src steps", log_data[b+1], exp16(20'h00602));
  endtask

  task automatic t_stall;
    int b = wr_n;
    bus_gnt = 1'b0;
    wr(0, 0, 20'h00800); wr(0, 1, 20'h00900); wr(0, 2, 0); wr(0, 3, 20'h05);
    req_pulse(2'b01);
    chk("R4 held req", bus_req, 1);
    chk("R4 held read", bus_we, 0);
    chk("R4 held addr", bus_addr, 20'h00800);
    chk("R4 no write yet", wr_n - b, 0);
    @(negedge clk); bus_gnt = 1'b1;
    repeat (6) @(negedge clk);
    chk("R4 completes", log_addr[b], 20'h00900);
    b = wr_n;
    req_pulse(2'b10);
    chk("R3 disabled drop", wr_n - b, 0);
  endtask

  task automatic t_wrap;
    int b = wr_n;
    wr(1, 0, 20'hFFFFE); wr(1, 1, 20'h05000); wr(1, 2, 20'd1); wr(1, 3, 20'h0D);
    req_pulse(2'b10); req_pulse(2'b10);
    chk("R5 wrap first", log_data[b], exp16(20'hFFFFE));
    chk("R5 wrap second", log_data[b+1], exp16(20'h00000));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_single16;
    t_byte_dst;
    t_repeat;
    t_prio;
    t_protected;
    t_both_fwd;
    t_stall;
    t_wrap;
    chk("R12 no register-range beat", reg_hits, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule